// File: doc/BRIEF.md
# ADC Channel-List Sequencer

This block sits between a bus and a multiplexed 12-bit converter. Software loads a list of one-byte entries. Each entry names an input channel, a gain code, a polarity and single-ended or differential wiring. Software then picks where conversions are triggered from: nowhere, a bus read, a scan tick or an edge on an external pin.

Each accepted trigger takes the next list entry and drives it onto the converter's select outputs. It then pulses a start strobe and waits for the converter's done strobe. The returned word goes into a result FIFO, unchanged, in offset binary. Software reads that FIFO and recovers the signed value by inverting bit 11.

A status word reports the levels of both FIFOs, a conversion in progress, a sticky overrun and a sticky half-full event. A write to the acknowledge address clears the two sticky flags.

Top module: `adc_list_sequencer`

## Requirements
- R1: After reset the status word reads 0x0004 (result FIFO empty), `adc_start` is low, both FIFOs are disabled, and the trigger mode is off.
- R2: Mode is bits 1:0 of the control word written at address 0x00, with 0=off, 1=bus read, 2=scan tick and 3=external edge. In mode 1, a bus read of address 0x00 makes `adc_start` high for exactly one cycle, in the cycle after the read.
- R3: A list entry drives the select outputs as follows: bits 3:0 on `adc_chan`, bits 5:4 on `adc_gain`, bit 6 on `adc_unipolar` and bit 7 on `adc_diff`. Entries are written at address 0x10.
- R4: The `adc_data` word present with `adc_done` is stored unchanged. Reads of address 0x10 return stored words in arrival order, in bits 11:0. A read of an empty result FIFO returns 0.
- R5: With control bit 2 clear, the sequencer stops after the last list entry, and further triggers start nothing.
- R6: With control bit 2 set, the entry after the last one is the first one.
- R7: A trigger from a source other than the selected one is ignored, and in mode 0 every trigger is ignored.
- R8: In mode 2, a one-cycle pulse on `scan_tick` starts one conversion.
- R9: In mode 3, a rising edge of `ext_trig` starts a conversion. With control bit 3 set, a falling edge starts it instead.
- R10: In the word written at address 0x02, bit 10 enables the result FIFO and bit 9 enables the list. A clear bit empties that FIFO, and list writes made while the list is disabled are dropped.
- R11: The status word is read at 0x04. Bit 4 is result full, bit 3 is result at least half full, bit 2 is result empty, bit 1 is list full and bit 0 is a conversion in progress.
- R12: A trigger that arrives while the result FIFO is full starts nothing, leaves the list position unchanged and sets sticky status bit 5.
- R13: Status bit 8 is set when the result FIFO reaches half full. Any write to address 0x04 clears bits 8 and 5.
- R14: A result push and a result read in the same cycle both take effect: the head word is returned and the fill level is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (reads at 0x00 and 0x10 have side effects) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while `bus_rd` is high |
| scan_tick | input | 1 | Scan-timer pulse |
| ext_trig | input | 1 | External trigger level |
| adc_start | output | 1 | One-cycle conversion start strobe |
| adc_chan | output | 4 | Selected channel |
| adc_gain | output | 2 | Selected gain code |
| adc_unipolar | output | 1 | Unipolar range select |
| adc_diff | output | 1 | Differential input select |
| adc_done | input | 1 | Converter result strobe |
| adc_data | input | 12 | Converter result, offset binary |

## Verification
Two functions can fall in the same cycle: a converter result being pushed into the result FIFO and a software read popping it. The bench fills the FIFO to its top and pops one word. It then raises `adc_done` and the result-read strobe on the same clock edge. The read must return the old head word. The drain that follows must yield exactly the expected words, with the new result last, before the empty bit returns.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    localparam int BUS_W  = 16;
    localparam int ADDR_W = 5;

    // Register map (byte addresses; read and write share some offsets)
    localparam logic [ADDR_W-1:0] A_START = 5'h00;  // read: launch
    localparam logic [ADDR_W-1:0] A_CTL1  = 5'h00;  // write: mode word
    localparam logic [ADDR_W-1:0] A_CTL2  = 5'h02;  // write: enables
    localparam logic [ADDR_W-1:0] A_STAT  = 5'h04;  // read: status
    localparam logic [ADDR_W-1:0] A_ACK   = 5'h04;  // write: clear flags
    localparam logic [ADDR_W-1:0] A_LIST  = 5'h10;  // write: list entry
    localparam logic [ADDR_W-1:0] A_RES   = 5'h10;  // read: result

    // Control bit positions
    localparam int B_CONT   = 2;
    localparam int B_FALL   = 3;
    localparam int B_LISTEN = 9;
    localparam int B_RESEN  = 10;

    typedef enum logic [1:0] {
        TRIG_OFF  = 2'd0,
        TRIG_SOFT = 2'd1,
        TRIG_SCAN = 2'd2,
        TRIG_EXT  = 2'd3
    } trig_mode_e;

    // One list entry, packed exactly as written on the bus
    typedef struct packed {
        logic       diff;
        logic       unipolar;
        logic [1:0] gain;
        logic [3:0] chan;
    } list_entry_t;

    function automatic logic [BUS_W-1:0] pack_status(
        input logic busy, input logic lst_full, input logic res_empty,
        input logic res_half, input logic res_full, input logic ovr,
        input logic hf_pend);
        logic [BUS_W-1:0] s;
        s    = '0;
        s[0] = busy;
        s[1] = lst_full;
        s[2] = res_empty;
        s[3] = res_half;
        s[4] = res_full;
        s[5] = ovr;
        s[8] = hf_pend;
        return s;
    endfunction

endpackage

// File: rtl/adcseq_fifo.sv
module adcseq_fifo #(
    parameter int WIDTH = 12,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/adcseq_list.sv
module adcseq_list import adcseq_pkg::*; #(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        wr,
    input  list_entry_t wentry,
    input  logic        adv,
    input  logic        wrap,
    output list_entry_t cur,
    output logic        avail,
    output logic        full
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    list_entry_t      mem [DEPTH];
    logic [CNT_W-1:0] cnt, ptr, ptr_nxt;

    assign full    = (cnt == CNT_W'(DEPTH));
    assign avail   = (ptr < cnt);
    assign cur     = mem[ptr[IDX_W-1:0]];
    assign ptr_nxt = ptr + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (wr && !full) mem[cnt[IDX_W-1:0]] <= wentry;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
            ptr <= '0;
        end else begin
            if (wr && !full) cnt <= cnt + CNT_W'(1);
            if (adv) ptr <= (wrap && ptr_nxt == cnt) ? '0 : ptr_nxt;
        end
    end
endmodule

// File: rtl/adcseq_trig.sv
module adcseq_trig import adcseq_pkg::*; #(
    parameter int EXT_SYNC = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  trig_mode_e mode,
    input  logic       falling,
    input  logic       sw_start,
    input  logic       scan_tick,
    input  logic       ext_in,
    output logic       fire
);
    logic ext_s, ext_q, ext_edge;

    generate
        if (EXT_SYNC > 0) begin : g_sync
            logic meta;
            always_ff @(posedge clk) meta <= rst ? 1'b0 : ext_in;
            assign ext_s = meta;
        end else begin : g_direct
            assign ext_s = ext_in;
        end
    endgenerate

    always_ff @(posedge clk) ext_q <= rst ? 1'b0 : ext_s;

    assign ext_edge = falling ? (ext_q && !ext_s) : (ext_s && !ext_q);

    always_comb begin
        case (mode)
            TRIG_SOFT: fire = sw_start;
            TRIG_SCAN: fire = scan_tick;
            TRIG_EXT:  fire = ext_edge;
            default:   fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/adc_list_sequencer.sv
module adc_list_sequencer import adcseq_pkg::*; #(
    parameter int RES_W      = 12,
    parameter int LIST_DEPTH = 16,
    parameter int RES_DEPTH  = 16,
    parameter int EXT_SYNC   = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              scan_tick,
    input  logic              ext_trig,
    output logic              adc_start,
    output logic [3:0]        adc_chan,
    output logic [1:0]        adc_gain,
    output logic              adc_unipolar,
    output logic              adc_diff,
    input  logic              adc_done,
    input  logic [RES_W-1:0]  adc_data
);
    localparam int RES_CNT_W = $clog2(RES_DEPTH+1);
    localparam int HALF      = RES_DEPTH / 2;

    trig_mode_e  ctl_mode;
    logic        ctl_cont, ctl_fall, ctl_res_en, ctl_list_en;
    logic        busy, overrun, hf_pend, hf_seen;
    list_entry_t sel_q, lst_cur;

    logic wr_ctl1, wr_ctl2, ack_wr, wr_list, rd_start, rd_res;
    logic fire, lst_avail, lst_full, candidate, accept, drop;
    logic [RES_W-1:0]     res_dout;
    logic [RES_CNT_W-1:0] res_cnt;
    logic res_empty, res_full, res_half, res_push;

    assign wr_ctl1  = bus_wr && (bus_addr == A_CTL1);
    assign wr_ctl2  = bus_wr && (bus_addr == A_CTL2);
    assign ack_wr   = bus_wr && (bus_addr == A_ACK);
    assign wr_list  = bus_wr && (bus_addr == A_LIST);
    assign rd_start = bus_rd && (bus_addr == A_START);
    assign rd_res   = bus_rd && (bus_addr == A_RES);

    adcseq_trig #(.EXT_SYNC(EXT_SYNC)) trig_i (
        .clk(clk), .rst(rst), .mode(ctl_mode), .falling(ctl_fall),
        .sw_start(rd_start), .scan_tick(scan_tick), .ext_in(ext_trig),
        .fire(fire)
    );

    adcseq_list #(.DEPTH(LIST_DEPTH)) list_i (
        .clk(clk), .rst(rst), .clr(!ctl_list_en),
        .wr(wr_list && ctl_list_en), .wentry(list_entry_t'(bus_wdata[7:0])),
        .adv(accept), .wrap(ctl_cont),
        .cur(lst_cur), .avail(lst_avail), .full(lst_full)
    );

    assign res_push = busy && adc_done && ctl_res_en;

    adcseq_fifo #(.WIDTH(RES_W), .DEPTH(RES_DEPTH)) res_i (
        .clk(clk), .rst(rst), .clr(!ctl_res_en),
        .push(res_push), .din(adc_data), .pop(rd_res),
        .dout(res_dout), .count(res_cnt), .empty(res_empty), .full(res_full)
    );

    assign candidate = fire && !busy && lst_avail;
    assign accept    = candidate && !res_full;
    assign drop      = candidate && res_full;
    assign res_half  = (res_cnt >= RES_CNT_W'(HALF));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_mode    <= TRIG_OFF;
            ctl_cont    <= 1'b0;
            ctl_fall    <= 1'b0;
            ctl_res_en  <= 1'b0;
            ctl_list_en <= 1'b0;
            busy        <= 1'b0;
            adc_start   <= 1'b0;
            sel_q       <= '0;
            overrun     <= 1'b0;
            hf_pend     <= 1'b0;
            hf_seen     <= 1'b0;
        end else begin
            if (wr_ctl1) begin
                ctl_mode <= trig_mode_e'(bus_wdata[1:0]);
                ctl_cont <= bus_wdata[B_CONT];
                ctl_fall <= bus_wdata[B_FALL];
            end
            if (wr_ctl2) begin
                ctl_res_en  <= bus_wdata[B_RESEN];
                ctl_list_en <= bus_wdata[B_LISTEN];
            end
            adc_start <= accept;
            if (accept) begin
                busy  <= 1'b1;
                sel_q <= lst_cur;
            end else if (adc_done) begin
                busy  <= 1'b0;
            end
            hf_seen <= res_half;
            if (drop)        overrun <= 1'b1;
            else if (ack_wr) overrun <= 1'b0;
            if (res_half && !hf_seen) hf_pend <= 1'b1;
            else if (ack_wr)          hf_pend <= 1'b0;
        end
    end

    assign adc_chan     = sel_q.chan;
    assign adc_gain     = sel_q.gain;
    assign adc_unipolar = sel_q.unipolar;
    assign adc_diff     = sel_q.diff;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                A_STAT: bus_rdata = pack_status(busy, lst_full, res_empty,
                                                res_half, res_full, overrun, hf_pend);
                A_RES:  if (!res_empty)
                            bus_rdata = {{(BUS_W-RES_W){1'b0}}, res_dout};
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk (
    input logic       clk,
    input logic       rst,
    input logic       adc_start,
    input logic       busy,
    input logic [1:0] ctl_mode,
    input logic       res_full,
    input logic       lst_avail,
    input logic       overrun,
    input logic       hf_pend,
    input logic       ack_wr
);
    // R2
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> !adc_start);
    // R11
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        adc_start |-> busy);
    // R7
    off_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_mode == 2'd0) |=> !adc_start);
    // R12
    full_block_chk: assert property (@(posedge clk) disable iff (rst)
        res_full |=> !adc_start);
    // R5
    no_entry_chk: assert property (@(posedge clk) disable iff (rst)
        !lst_avail |=> !adc_start);
    // R12
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (overrun && !ack_wr) |=> overrun);
    // R13
    hf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (hf_pend && !ack_wr) |=> hf_pend);
endmodule

bind adc_list_sequencer adcseq_chk chk_i (
    .clk(clk), .rst(rst), .adc_start(adc_start), .busy(busy),
    .ctl_mode(ctl_mode), .res_full(res_full), .lst_avail(lst_avail),
    .overrun(overrun), .hf_pend(hf_pend), .ack_wr(ack_wr)
);

// File: tb/adc_list_sequencer_tb_top.sv
module adc_list_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        scan_tick = 1'b0, ext_trig = 1'b0;
    logic        adc_start, adc_unipolar, adc_diff;
    logic [3:0]  adc_chan;
    logic [1:0]  adc_gain;
    logic        adc_done = 1'b0;
    logic [11:0] adc_data = '0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    adc_list_sequencer dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .scan_tick(scan_tick), .ext_trig(ext_trig), .adc_start(adc_start),
        .adc_chan(adc_chan), .adc_gain(adc_gain), .adc_unipolar(adc_unipolar),
        .adc_diff(adc_diff), .adc_done(adc_done), .adc_data(adc_data)
    );

    // {list entry, converter word}
    localparam logic [19:0] VECS [6] = '{
        20'h00_800, 20'h1F_FFF, 20'h25_000,
        20'h4A_123, 20'h83_7FF, 20'hFC_A5A
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Looks for a start strobe over a few cycles; returns the selects seen
    task automatic wait_start(output logic seen, output logic [7:0] sel);
        seen = 1'b0; sel = '0;
        for (int k = 0; k < 4; k++) begin
            if (adc_start) begin
                seen = 1'b1;
                sel = {adc_diff, adc_unipolar, adc_gain, adc_chan};
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic finish_conv(input logic [11:0] d);
        adc_done = 1'b1; adc_data = d;
        @(negedge clk);
        adc_done = 1'b0;
    endtask

    // Software trigger, expect a start with the given entry, return data
    task automatic soft_conv(input string req, input logic [7:0] ent, input logic [11:0] d);
        logic [15:0] r; logic s; logic [7:0] sel;
        bus_read(5'h00, r);
        wait_start(s, sel);
        chk(req, {15'd0, s}, 16'd1);
        chk(req, {8'd0, sel}, {8'd0, ent});
        if (s) finish_conv(d);
    endtask

    task automatic expect_none(input string req);
        logic s; logic [7:0] sel;
        wait_start(s, sel);
        chk(req, {15'd0, s}, 16'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] r;
        logic s;
        logic [7:0] sel;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        bus_read(5'h04, r);
        chk("R1 status", r, 16'h0004);
        chk("R1 start", {15'd0, adc_start}, 16'd0);
        bus_read(5'h10, r);
        chk("R4 empty read", r, 16'h0000);

        // Table walk: R2, R3, R4 under software trigger
        bus_write(5'h02, 16'h0600);
        for (int i = 0; i < 6; i++) bus_write(5'h10, {8'd0, VECS[i][19:12]});
        bus_write(5'h00, 16'h0001);
        for (int i = 0; i < 6; i++) begin
            soft_conv("R2 R3 table", VECS[i][19:12], VECS[i][11:0]);
            bus_read(5'h10, r);
            chk("R4 table data", r, {4'd0, VECS[i][11:0]});
        end
        bus_read(5'h04, r);
        chk("R11 status drained", r, 16'h0004);

        // R5: list exhausted, not continuous
        bus_read(5'h00, r);
        expect_none("R5 stop at end");

        // R6: continuous wrap
        bus_write(5'h02, 16'h0400);
        bus_write(5'h02, 16'h0600);
        bus_write(5'h10, 16'h00D7);
        bus_write(5'h10, 16'h003A);
        bus_write(5'h00, 16'h0005);
        soft_conv("R6 wrap", 8'hD7, 12'h011);
        soft_conv("R6 wrap", 8'h3A, 12'h022);
        soft_conv("R6 wrap", 8'hD7, 12'h033);
        bus_read(5'h10, r); chk("R6 data", r, 16'h0011);
        bus_read(5'h10, r); chk("R6 data", r, 16'h0022);
        bus_read(5'h10, r); chk("R6 data", r, 16'h0033);

        // R7: mode off, and wrong source
        bus_write(5'h00, 16'h0004);
        bus_read(5'h00, r);
        expect_none("R7 mode off");
        bus_write(5'h00, 16'h0005);
        @(negedge clk); scan_tick = 1'b1;
        @(negedge clk); scan_tick = 1'b0;
        expect_none("R7 scan in soft mode");

        // R8: scan trigger
        bus_write(5'h00, 16'h0006);
        @(negedge clk); scan_tick = 1'b1;
        @(negedge clk); scan_tick = 1'b0;
        wait_start(s, sel);
        chk("R8 scan start", {15'd0, s}, 16'd1);
        chk("R8 scan entry", {8'd0, sel}, 16'h003A);
        if (s) finish_conv(12'h044);
        bus_read(5'h10, r); chk("R8 data", r, 16'h0044);

        // R9: external edges
        bus_write(5'h00, 16'h0007);
        bus_read(5'h00, r);
        expect_none("R7 soft read in ext mode");
        @(negedge clk); ext_trig = 1'b1;
        wait_start(s, sel);
        chk("R9 rising start", {15'd0, s}, 16'd1);
        chk("R9 rising entry", {8'd0, sel}, 16'h00D7);
        if (s) finish_conv(12'h055);
        bus_read(5'h10, r); chk("R9 data", r, 16'h0055);
        @(negedge clk); ext_trig = 1'b0;
        expect_none("R9 falling ignored in rising mode");
        bus_write(5'h00, 16'h000F);
        @(negedge clk); ext_trig = 1'b1;
        expect_none("R9 rising ignored in falling mode");
        @(negedge clk); ext_trig = 1'b0;
        wait_start(s, sel);
        chk("R9 falling start", {15'd0, s}, 16'd1);
        chk("R9 falling entry", {8'd0, sel}, 16'h003A);
        if (s) finish_conv(12'h066);
        bus_read(5'h10, r); chk("R9 data", r, 16'h0066);

        // R11, R12, R13: fill result FIFO
        bus_write(5'h02, 16'h0000);
        bus_write(5'h02, 16'h0600);
        for (int i = 0; i < 16; i++) begin
            bus_read(5'h04, r);
            chk("R11 list full bit", {15'd0, r[1]}, 16'd0);
            bus_write(5'h10, 16'(i));
        end
        bus_write(5'h00, 16'h0005);
        for (int i = 0; i < 16; i++) begin
            soft_conv("R11 fill", 8'(i), 12'h100 + 12'(i));
            if (i == 6) begin
                bus_read(5'h04, r);
                chk("R11 below half", r, 16'h0002);
            end
            if (i == 7) begin
                bus_read(5'h04, r);
                chk("R13 half pending", r, 16'h010A);
            end
        end
        bus_read(5'h04, r);
        chk("R11 full", r, 16'h011A);
        bus_read(5'h00, r);
        expect_none("R12 dropped when full");
        bus_read(5'h04, r);
        chk("R12 overrun", r, 16'h013A);
        bus_write(5'h04, 16'h0000);
        bus_read(5'h04, r);
        chk("R13 ack clears", r, 16'h001A);

        // R14: push and pop in one cycle
        bus_read(5'h10, r);
        chk("R4 head", r, 16'h0100);
        bus_read(5'h00, r);
        wait_start(s, sel);
        chk("R12 position kept", {8'd0, sel}, 16'h0000);
        adc_done = 1'b1; adc_data = 12'hABC;
        bus_rd = 1'b1; bus_addr = 5'h10;
        #1 r = bus_rdata;
        @(negedge clk);
        adc_done = 1'b0; bus_rd = 1'b0;
        chk("R14 same-cycle read", r, 16'h0101);
        for (int i = 2; i < 16; i++) begin
            bus_read(5'h10, r);
            chk("R14 drain", r, 16'h0100 + 16'(i));
        end
        bus_read(5'h10, r);
        chk("R14 pushed word last", r, 16'h0ABC);
        bus_read(5'h04, r);
        chk("R14 empty after drain", r, 16'h0006);

        // R10: flushes and disabled list writes
        bus_write(5'h00, 16'h0001);
        soft_conv("R10 one more", 8'h01, 12'h555);
        bus_read(5'h04, r);
        chk("R10 holding", r, 16'h0002);
        bus_write(5'h02, 16'h0200);
        bus_read(5'h04, r);
        chk("R10 result flush", r, 16'h0006);
        bus_write(5'h02, 16'h0000);
        bus_read(5'h04, r);
        chk("R10 list flush", r, 16'h0004);
        bus_write(5'h10, 16'h0011);
        bus_write(5'h02, 16'h0600);
        bus_read(5'h00, r);
        expect_none("R10 disabled write dropped");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule